// File: doc/BRIEF.md
# Vertex Array Descriptor Unpacker

This block sits on a command stream and turns one vertex array descriptor packet into a stream of per-array records. The packet opens with a dword that says how many arrays it describes. That dword is flagged by a start-of-packet marker. The arrays then come in pairs. Each pair shares one packed dword carrying two entry-size/stride bytes, followed by one base-pointer dword per array.

A consumer downstream, such as a vertex fetch engine, takes one record per array. Each record holds the array's position in the packet, its entry size in dwords, its stride, its base pointer, and a flag on the final array. When the array count is odd, the last pair has no second pointer, so its group is only two dwords long. The parser knows this and closes the packet after the lone pointer. A new start-of-packet that arrives before the current packet is complete is reported on a one-cycle error flag, and decoding starts over from the new dword. Both stream edges use valid/ready handshakes, and no dword is taken while a finished record is still waiting.

Top module: `vtx_array_desc_parser`

## Requirements
- R1: After synchronous reset, `rec_valid` and `pkt_err` are 0 and `cmd_ready` is 1.
- R2: A dword accepted with `cmd_sop`=1 is the count dword, and its low `CNT_W` bits give the array count N. The packet yields exactly N records, with `rec_index` running 0, 1, … N-1 in order.
- R3: In the packed dword of a pair, bits [7:0] are the entry size and bits [15:8] the stride of the pair's first array. Bits [23:16] and [31:24] are the size and stride of the second array.
- R4: The dword after the packed dword is the first array's base pointer, and the dword after that is the second array's pointer. A record is presented on the cycle after its pointer dword is accepted, and the first array of a pair is always presented before the second.
- R5: For odd N, the final pair consists of only the packed dword and one pointer. The packet ends after that pointer, and any upper half in that packed dword has no effect.
- R6: `rec_last` is 1 on the record whose index is N-1 and 0 on every other record.
- R7: N = 0 produces no record, and the parser is ready for the next packet right after the count dword. Accepting any count dword leaves `rec_valid` low on the following cycle.
- R8: A `cmd_sop` dword accepted while a packet is still incomplete raises `pkt_err` for exactly the following cycle and is decoded as a new count dword. Otherwise `pkt_err` stays 0.
- R9: While `rec_valid`=1 and `rec_ready`=0, the record fields are held stable and `cmd_ready` is 0. While `rec_valid`=0, `cmd_ready` is 1.
- R10: Dwords accepted without `cmd_sop` while no packet is open are discarded and produce no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command dword valid |
| cmd_ready | output | 1 | Command dword accepted when high with valid |
| cmd_data | input | 32 | Command dword |
| cmd_sop | input | 1 | Marks the count dword that opens a packet |
| rec_valid | output | 1 | Record valid |
| rec_ready | input | 1 | Consumer accepts record |
| rec_index | output | CNT_W | Array position within packet |
| rec_size | output | 8 | Entry size in dwords |
| rec_stride | output | 8 | Stride |
| rec_ptr | output | 32 | Base pointer |
| rec_last | output | 1 | Final array of packet |
| pkt_err | output | 1 | One-cycle pulse: packet cut short by a new start |

## Verification
The case that matters is a record being handed to the consumer in the same cycle that the next pointer dword is taken. The output slot is freed and refilled on one edge, so a wrong ready equation would either lose a record or take a dword twice. The bench provokes this by running packets while `rec_ready` follows always-high, alternating and one-in-four patterns. A scoreboard judges the result by the exact order and contents of the records. A second collision pairs an early start-of-packet with a record that is still stalled. There the bench checks that the pending record still arrives unchanged, that `pkt_err` pulses, and that the new packet decodes from its own count.

// File: rtl/vad_pkg.sv
package vad_pkg;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 2 * BYTE_W;
  localparam int WORD_W = 2 * HALF_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PACK  = 2'd1,
    ST_PTR_A = 2'd2,
    ST_PTR_B = 2'd3
  } vad_state_t;

  typedef struct packed {
    logic [BYTE_W-1:0] stride;
    logic [BYTE_W-1:0] size;
  } vad_half_t;
endpackage

// File: rtl/vad_ctrl.sv
module vad_ctrl
  import vad_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             sop,
  input  logic [CNT_W-1:0] cnt_in,
  output logic             load_pair,
  output logic             emit_a,
  output logic             emit_b,
  output logic             emit_last,
  output logic [CNT_W-1:0] emit_idx,
  output logic             err
);
  vad_state_t       state;
  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] idx;
  logic             body;

  assign body      = take && !sop;
  assign load_pair = body && (state == ST_PACK);
  assign emit_a    = body && (state == ST_PTR_A);
  assign emit_b    = body && (state == ST_PTR_B);
  assign emit_last = (remain == CNT_W'(1));
  assign emit_idx  = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      remain <= '0;
      idx    <= '0;
      err    <= 1'b0;
    end else begin
      err <= 1'b0;
      if (take && sop) begin
        err    <= (state != ST_IDLE);
        remain <= cnt_in;
        idx    <= '0;
        state  <= (cnt_in == '0) ? ST_IDLE : ST_PACK;
      end else if (body) begin
        unique case (state)
          ST_IDLE: state <= ST_IDLE;
          ST_PACK: state <= ST_PTR_A;
          ST_PTR_A: begin
            remain <= remain - CNT_W'(1);
            idx    <= idx + CNT_W'(1);
            state  <= emit_last ? ST_IDLE : ST_PTR_B;
          end
          ST_PTR_B: begin
            remain <= remain - CNT_W'(1);
            idx    <= idx + CNT_W'(1);
            state  <= emit_last ? ST_IDLE : ST_PACK;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/vad_pair_reg.sv
module vad_pair_reg
  import vad_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  input  logic              sel_upper,
  output vad_half_t         half
);
  vad_half_t lo_q;
  vad_half_t hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (load) begin
      lo_q <= din[HALF_W-1:0];
      hi_q <= din[WORD_W-1:HALF_W];
    end
  end

  assign half = sel_upper ? hi_q : lo_q;
endmodule

// File: rtl/vad_out_stage.sv
module vad_out_stage
  import vad_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int PTR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [IDX_W-1:0]  idx_in,
  input  vad_half_t         half_in,
  input  logic [PTR_W-1:0]  ptr_in,
  input  logic              last_in,
  input  logic              ready,
  output logic              valid,
  output logic [IDX_W-1:0]  idx_q,
  output logic [BYTE_W-1:0] size_q,
  output logic [BYTE_W-1:0] stride_q,
  output logic [PTR_W-1:0]  ptr_q,
  output logic              last_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= 1'b0;
      idx_q    <= '0;
      size_q   <= '0;
      stride_q <= '0;
      ptr_q    <= '0;
      last_q   <= 1'b0;
    end else begin
      if (load) begin
        valid    <= 1'b1;
        idx_q    <= idx_in;
        size_q   <= half_in.size;
        stride_q <= half_in.stride;
        ptr_q    <= ptr_in;
        last_q   <= last_in;
      end else if (ready) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vtx_array_desc_parser.sv
module vtx_array_desc_parser
  import vad_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic              cmd_sop,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [CNT_W-1:0]  rec_index,
  output logic [BYTE_W-1:0] rec_size,
  output logic [BYTE_W-1:0] rec_stride,
  output logic [WORD_W-1:0] rec_ptr,
  output logic              rec_last,
  output logic              pkt_err
);
  logic             take;
  logic             load_pair;
  logic             emit_a;
  logic             emit_b;
  logic             emit_last;
  logic [CNT_W-1:0] emit_idx;
  vad_half_t        half;

  assign cmd_ready = !rec_valid || rec_ready;
  assign take      = cmd_valid && cmd_ready;

  vad_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .sop       (cmd_sop),
    .cnt_in    (cmd_data[CNT_W-1:0]),
    .load_pair (load_pair),
    .emit_a    (emit_a),
    .emit_b    (emit_b),
    .emit_last (emit_last),
    .emit_idx  (emit_idx),
    .err       (pkt_err)
  );

  vad_pair_reg u_pair (
    .clk       (clk),
    .rst       (rst),
    .load      (load_pair),
    .din       (cmd_data),
    .sel_upper (emit_b),
    .half      (half)
  );

  vad_out_stage #(.IDX_W(CNT_W), .PTR_W(WORD_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (emit_a || emit_b),
    .idx_in   (emit_idx),
    .half_in  (half),
    .ptr_in   (cmd_data),
    .last_in  (emit_last),
    .ready    (rec_ready),
    .valid    (rec_valid),
    .idx_q    (rec_index),
    .size_q   (rec_size),
    .stride_q (rec_stride),
    .ptr_q    (rec_ptr),
    .last_q   (rec_last)
  );
endmodule

// File: rtl/vtx_array_desc_parser_chk.sv
module vtx_array_desc_parser_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             cmd_sop,
  input logic             rec_valid,
  input logic             rec_ready,
  input logic [CNT_W-1:0] rec_index,
  input logic [7:0]       rec_size,
  input logic [7:0]       rec_stride,
  input logic [31:0]      rec_ptr,
  input logic             rec_last,
  input logic             pkt_err
);
  AST_HOLD_RECORD: assert property (@(posedge clk) disable iff (rst)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_index) && $stable(rec_size)
      && $stable(rec_stride) && $stable(rec_ptr) && $stable(rec_last)); // R9
  AST_STALL_INPUT: assert property (@(posedge clk) disable iff (rst)
    rec_valid && !rec_ready |-> !cmd_ready); // R9
  AST_FREE_SLOT: assert property (@(posedge clk) disable iff (rst)
    !rec_valid |-> cmd_ready); // R9
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    pkt_err |-> $past(cmd_valid && cmd_ready && cmd_sop)); // R8
  AST_COUNT_NO_REC: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready && cmd_sop |=> !rec_valid); // R7
endmodule

bind vtx_array_desc_parser vtx_array_desc_parser_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_sop    (cmd_sop),
  .rec_valid  (rec_valid),
  .rec_ready  (rec_ready),
  .rec_index  (rec_index),
  .rec_size   (rec_size),
  .rec_stride (rec_stride),
  .rec_ptr    (rec_ptr),
  .rec_last   (rec_last),
  .pkt_err    (pkt_err)
);

// File: tb/vtx_array_desc_parser_test.sv
module vtx_array_desc_parser_test;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [31:0]      cmd_data = '0;
  logic             cmd_sop = 1'b0;
  logic             rec_valid;
  logic             rec_ready = 1'b1;
  logic [CNT_W-1:0] rec_index;
  logic [7:0]       rec_size;
  logic [7:0]       rec_stride;
  logic [31:0]      rec_ptr;
  logic             rec_last;
  logic             pkt_err;

  int checks = 0;
  int errors = 0;
  int bp_mode = 0;
  int cyc = 0;
  bit pkt_open = 0;

  typedef struct {
    int idx; int size; int stride; int ptr; bit last;
  } rec_t;
  rec_t exp_q[$];

  always #4 clk = ~clk;

  vtx_array_desc_parser #(.CNT_W(CNT_W)) uut (.*);

  function automatic int f_size(int p, int i);   return (p * 16 + i + 1) & 255; endfunction
  function automatic int f_stride(int p, int i); return (p * 3 + i * 4 + 2) & 255; endfunction
  function automatic int f_ptr(int p, int i);    return 32'h1000_0000 + (p << 16) + i * 64; endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    case (bp_mode)
      0: rec_ready = 1'b1;
      1: rec_ready = cyc[0];
      default: rec_ready = (cyc % 4) == 0;
    endcase
  end

  bit   was_stalled = 0;
  rec_t held;
  always @(negedge clk) begin
    #2;
    if (!rst && rec_valid) begin
      if (was_stalled)
        check(rec_ptr == held.ptr && int'(rec_index) == held.idx, "R9", "held record ptr",
              rec_ptr, held.ptr);
      if (rec_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R2", "unexpected record index", int'(rec_index), -1);
        end else begin
          rec_t e;
          e = exp_q.pop_front();
          check(int'(rec_index) == e.idx, "R2", "index", int'(rec_index), e.idx);
          check(int'(rec_size) == e.size && int'(rec_stride) == e.stride, "R3", "size/stride",
                {rec_stride, rec_size}, (e.stride << 8) | e.size);
          check(rec_ptr == e.ptr, "R4", "pointer", rec_ptr, e.ptr);
          check(rec_last == e.last, "R6", "last flag", int'(rec_last), int'(e.last));
        end
      end
      was_stalled = !rec_ready;
      held.ptr = rec_ptr;
      held.idx = int'(rec_index);
    end else begin
      was_stalled = 0;
    end
  end

  task automatic send(logic [31:0] d, bit sop, bit exp_err);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_data = d; cmd_sop = sop;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    cmd_valid = 1'b0; cmd_sop = 1'b0;
    check(pkt_err == exp_err, "R8", "error pulse", int'(pkt_err), int'(exp_err));
  endtask

  // budget < 0: full packet; otherwise stop after that many payload dwords
  task automatic send_packet(int p, int n, int budget);
    int left = budget;
    send(32'(n) | 32'hABCD_0000, 1'b1, pkt_open);
    pkt_open = (n != 0);
    for (int i = 0; i < n; i += 2) begin
      logic [31:0] packed_w;
      packed_w[15:0] = 16'((f_stride(p, i) << 8) | f_size(p, i));
      packed_w[31:16] = (i + 1 < n) ? 16'((f_stride(p, i + 1) << 8) | f_size(p, i + 1)) : 16'hEEEE;
      if (left == 0) return;
      send(packed_w, 1'b0, 1'b0); left--;
      for (int k = i; k < i + 2 && k < n; k++) begin
        rec_t e;
        if (left == 0) return;
        e.idx = k; e.size = f_size(p, k); e.stride = f_stride(p, k);
        e.ptr = f_ptr(p, k); e.last = (k == n - 1);
        exp_q.push_back(e);
        send(32'(f_ptr(p, k)), 1'b0, 1'b0); left--;
      end
    end
    pkt_open = 0;
  endtask

  task automatic drain(string req);
    for (int t = 0; t < 300 && exp_q.size() != 0; t++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, req, "records outstanding", exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    check(rec_valid == 0, "R1", "rec_valid after reset", int'(rec_valid), 0);
    check(pkt_err == 0, "R1", "pkt_err after reset", int'(pkt_err), 0);
    check(cmd_ready == 1, "R1", "cmd_ready after reset", int'(cmd_ready), 1);

    // R10: stray dwords while idle
    send(32'h5555_0003, 1'b0, 1'b0);
    send(32'h1234_5678, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    #2 check(rec_valid == 0, "R10", "record from stray dword", int'(rec_valid), 0);

    // R2/R3/R4/R6: even count, free-flowing output
    send_packet(1, 4, -1);
    drain("R2");
    // R5: odd counts, with back-pressure
    bp_mode = 1;
    send_packet(2, 5, -1);
    drain("R5");
    send_packet(3, 1, -1);
    drain("R5");
    // R7: zero count then an immediate packet
    bp_mode = 0;
    send_packet(4, 0, -1);
    #2 check(rec_valid == 0, "R7", "record after zero count", int'(rec_valid), 0);
    send_packet(5, 2, -1);
    drain("R7");
    // R8: early start-of-packet with a stalled record
    bp_mode = 2;
    send_packet(6, 6, 4);
    send_packet(7, 3, -1);
    drain("R8");
    send_packet(8, 4, 1);
    send_packet(9, 7, -1);
    drain("R8");
    // R9: long packet under heavy stall
    send_packet(10, 9, -1);
    drain("R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule